// File: doc/BRIEF.md
# Soft Reset and Clock Gate Controller

This block is the top control register of a peripheral. It holds two bits, a soft-reset request and a clock-gate state. It drives a reset and a clock enable into the peripheral's channel logic. Software can write the register directly or change single bits through set, clear and toggle alias addresses. A small bank of channel registers sits behind the same port. This bank is the logic being reset and gated.

Software asserts soft reset to put the channel logic into reset. The hardware then counts a fixed number of cycles and sets the clock-gate bit by itself. Software polls that bit to learn that the reset has taken hold. It then clears soft reset, which leaves the gate bit set. Last, it clears the gate bit and reads back 0 to confirm the clock is running again. Clock gating is modelled as an enable on the channel registers, not as a gating cell.

Top module: `srst_gate_ctrl`

## Requirements
- R1: After `rst_ni` is released, the control register reads 0, `chan_rst_o` is 0, `clk_en_o` is 1, and every channel register reads `CH_RST_VAL`.
- R2: The control register sits at byte offset 0x0, with soft reset in bit 31 and clock gate in bit 30. A write at offset 0x0 loads both bits. Offset 0x4 sets the bits that are 1 in the write data, 0x8 clears them and 0xC toggles them. A read at any of the four offsets returns the register, with all other bits 0.
- R3: `chan_rst_o` equals the soft-reset bit and `clk_en_o` is the inverse of the clock-gate bit, with no added cycles.
- R4: Take the clock edge at which soft reset becomes 1 with the gate bit at 0. The gate bit then reads 1 after exactly `SET_DLY` further edges, as long as soft reset stays 1. If soft reset is cleared first, the gate bit stays 0.
- R5: While soft reset and the gate bit are both 1, a write that would clear the gate bit and leave soft reset at 1 leaves the gate bit set.
- R6: Clearing soft reset leaves the gate bit at 1 until software clears it.
- R7: With soft reset at 0, clearing the gate bit ungates the clock (`clk_en_o` is 1). The gate bit only goes from 1 to 0 through a register write.
- R8: From the edge after soft reset becomes 1, and for as long as it stays 1, every channel register reads `CH_RST_VAL`.
- R9: A write to a channel register is ignored while the clock is gated.
- R10: Channel register i is at byte offset 0x10 + 4*i. It holds the low `CH_W` bits of the write data and reads back zero-extended. Reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| chan_rst_o | output | 1 | Reset to channel logic, active high |
| clk_en_o | output | 1 | Clock enable to channel logic |

## Verification
The bench builds the block with `SET_DLY` = 5, two channels of 16 bits and a nonzero channel reset value of 0x00A5. The nonzero reset value separates a channel cleared by soft reset from one that was never written. Wide write data shows the truncation to `CH_W` bits. With a five-cycle delay, the bench can sample every edge between the soft-reset request and the gate bit setting, so a delay that is one cycle off is caught. The same delay leaves room to drop soft reset part-way through the count and see that the gate stays open.

// File: rtl/srst_gate_pkg.sv
package srst_gate_pkg;
  localparam int DATA_W   = 32;
  localparam int SRST_BIT = 31;
  localparam int GATE_BIT = 30;
  localparam int CH_BASE  = 'h10;

  // op encoding matches addr[3:2] of the control aliases
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } ctrl_op_e;

  // bits ordered {srst, gate}
  function automatic logic [1:0] apply_op(ctrl_op_e op, logic [1:0] cur, logic [1:0] d);
    case (op)
      OP_WRITE: apply_op = d;
      OP_SET:   apply_op = cur | d;
      OP_CLR:   apply_op = cur & ~d;
      default:  apply_op = cur ^ d;
    endcase
  endfunction
endpackage

// File: rtl/srst_ctrl_reg.sv
module srst_ctrl_reg
  import srst_gate_pkg::*;
#(
  parameter int SET_DLY = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  ctrl_op_e   op_i,
  input  logic [1:0] wbits_i,
  output logic       srst_o,
  output logic       gate_o
);
  localparam int CNT_W = (SET_DLY > 1) ? $clog2(SET_DLY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SET_DLY - 1);

  logic             srst_q, gate_q;
  logic             srst_d, gate_d;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       nxt;

  always_comb begin
    nxt    = wr_i ? apply_op(op_i, {srst_q, gate_q}, wbits_i) : {srst_q, gate_q};
    srst_d = nxt[1];
    gate_d = nxt[0];
    // gate cannot be released while reset is still held
    if (srst_d && gate_q) gate_d = 1'b1;
    // delayed self-set once reset has been held long enough
    if (srst_d && srst_q && !gate_q && cnt_q == CNT_LAST) gate_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0;
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      srst_q <= srst_d;
      gate_q <= gate_d;
      if (!srst_q || gate_q)      cnt_q <= '0;
      else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign srst_o = srst_q;
  assign gate_o = gate_q;
endmodule

// File: rtl/srst_chan_bank.sv
module srst_chan_bank #(
  parameter int              NUM_CH     = 2,
  parameter int              CH_W       = 16,
  parameter logic [CH_W-1:0] CH_RST_VAL = '0,
  localparam int             IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         en_i,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [CH_W-1:0]              wdata_i,
  output logic [NUM_CH-1:0][CH_W-1:0]  regs_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_o[i] <= CH_RST_VAL;
      else if (clr_i)                               regs_o[i] <= CH_RST_VAL;
      else if (en_i && wr_i && idx_i == IDX_W'(i))  regs_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/srst_gate_ctrl.sv
module srst_gate_ctrl
  import srst_gate_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter int              SET_DLY    = 4,
  parameter int              NUM_CH     = 2,
  parameter int              CH_W       = 16,
  parameter logic [CH_W-1:0] CH_RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              chan_rst_o,
  output logic              clk_en_o
);
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_END = CH_BASE + 4 * NUM_CH;

  logic                        ctrl_hit, ch_hit;
  logic                        srst, gate;
  logic [ADDR_W-1:0]           ch_off;
  logic [IDX_W-1:0]            ch_idx;
  logic [NUM_CH-1:0][CH_W-1:0] ch_regs;

  assign ctrl_hit = (addr_i >> 4) == '0 && addr_i[1:0] == 2'b00;
  assign ch_hit   = int'(addr_i) >= CH_BASE && int'(addr_i) < CH_END && addr_i[1:0] == 2'b00;
  assign ch_off   = addr_i - ADDR_W'(CH_BASE);
  assign ch_idx   = ch_off[IDX_W+1:2];

  srst_ctrl_reg #(.SET_DLY(SET_DLY)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_i && we_i && ctrl_hit),
    .op_i    (ctrl_op_e'(addr_i[3:2])),
    .wbits_i ({wdata_i[SRST_BIT], wdata_i[GATE_BIT]}),
    .srst_o  (srst),
    .gate_o  (gate)
  );

  srst_chan_bank #(
    .NUM_CH     (NUM_CH),
    .CH_W       (CH_W),
    .CH_RST_VAL (CH_RST_VAL)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst),
    .en_i    (!gate),
    .wr_i    (req_i && we_i && ch_hit),
    .idx_i   (ch_idx),
    .wdata_i (wdata_i[CH_W-1:0]),
    .regs_o  (ch_regs)
  );

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o[SRST_BIT] = srst;
      rdata_o[GATE_BIT] = gate;
    end else if (ch_hit) begin
      rdata_o[CH_W-1:0] = ch_regs[ch_idx];
    end
  end

  assign chan_rst_o = srst;
  assign clk_en_o   = !gate;

  logic unused_w;
  assign unused_w = ^{wdata_i, ch_off};
endmodule

// File: rtl/srst_gate_ctrl_chk.sv
module srst_gate_ctrl_chk #(
  parameter int              ADDR_W     = 8,
  parameter int              SET_DLY    = 4,
  parameter int              NUM_CH     = 2,
  parameter int              CH_W       = 16,
  parameter logic [CH_W-1:0] CH_RST_VAL = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              chan_rst_o,
  input logic              clk_en_o
);
  logic [15:0] hold_cnt;
  logic        wr, ch_rd;

  assign wr    = req_i && we_i;
  assign ch_rd = req_i && !we_i && int'(addr_i) >= 'h10 &&
                 int'(addr_i) < 'h10 + 4 * NUM_CH && addr_i[1:0] == 2'b00;

  // cycles spent in reset with the clock still running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hold_cnt <= '0;
    else if (!chan_rst_o || !clk_en_o) hold_cnt <= '0;
    else if (hold_cnt != 16'hFFFF)  hold_cnt <= hold_cnt + 1'b1;
  end

  p_gate_on_time_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_rst_o && clk_en_o && !wr && int'(hold_cnt) == SET_DLY - 1) |=> !clk_en_o);

  p_gate_not_early_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_rst_o && clk_en_o && !wr && int'(hold_cnt) < SET_DLY - 1) |=> clk_en_o);

  p_gate_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_rst_o && !clk_en_o) |=> (!clk_en_o || !chan_rst_o));

  p_ungate_by_sw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |=> (!clk_en_o || $past(wr)));

  p_chan_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_rst_o && $past(chan_rst_o) && ch_rd) |-> rdata_o[CH_W-1:0] == CH_RST_VAL);
endmodule

bind srst_gate_ctrl srst_gate_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .SET_DLY    (SET_DLY),
  .NUM_CH     (NUM_CH),
  .CH_W       (CH_W),
  .CH_RST_VAL (CH_RST_VAL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .chan_rst_o (chan_rst_o),
  .clk_en_o   (clk_en_o)
);

// File: tb/srst_gate_ctrl_tb_top.sv
module srst_gate_ctrl_tb_top;
  localparam int          DLY    = 5;
  localparam logic [15:0] RSTV   = 16'h00A5;
  localparam logic [31:0] RSTV32 = 32'h0000_00A5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        chan_rst_o, clk_en_o;
  int          checks = 0, fails = 0;

  always #4 clk = ~clk;

  srst_gate_ctrl #(
    .ADDR_W(8), .SET_DLY(DLY), .NUM_CH(2), .CH_W(16), .CH_RST_VAL(RSTV)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .chan_rst_o(chan_rst_o), .clk_en_o(clk_en_o)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [18] = '{
    '{1'b1, 8'h10, 32'h0000_1234, 32'h0},
    '{1'b0, 8'h10, 32'h0,         32'h0000_1234}, // R10
    '{1'b1, 8'h14, 32'h0001_BEEF, 32'h0},
    '{1'b0, 8'h14, 32'h0,         32'h0000_BEEF}, // R10 truncation
    '{1'b1, 8'h04, 32'h4000_0000, 32'h0},
    '{1'b0, 8'h00, 32'h0,         32'h4000_0000}, // R2 set alias
    '{1'b1, 8'h10, 32'h0000_5555, 32'h0},
    '{1'b0, 8'h10, 32'h0,         32'h0000_1234}, // R9 gated write dropped
    '{1'b1, 8'h08, 32'h4000_0000, 32'h0},
    '{1'b0, 8'h08, 32'h0,         32'h0},         // R7 clear alias
    '{1'b1, 8'h0C, 32'h4000_0000, 32'h0},
    '{1'b0, 8'h04, 32'h0,         32'h4000_0000}, // R2 toggle on
    '{1'b1, 8'h0C, 32'h4000_0000, 32'h0},
    '{1'b0, 8'h0C, 32'h0,         32'h0},         // R2 toggle off
    '{1'b1, 8'h00, 32'h4000_FFFF, 32'h0},
    '{1'b0, 8'h00, 32'h0,         32'h4000_0000}, // R2 plain write, other bits 0
    '{1'b1, 8'h00, 32'h0,         32'h0},
    '{1'b0, 8'h18, 32'h0,         32'h0}          // R10 unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h00, r); chk("R1 ctrl", r, 32'h0);
    chk("R1 chan_rst_o", {31'b0, chan_rst_o}, 32'h0);
    chk("R1 clk_en_o", {31'b0, clk_en_o}, 32'h1);
    rd(8'h10, r); chk("R1 ch0", r, RSTV32);
    rd(8'h14, r); chk("R1 ch1", r, RSTV32);

    for (int i = 0; i < 18; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, r);
        chk($sformatf("table[%0d]", i), r, VEC[i].exp);
      end
    end

    // R3/R4 soft reset with delayed gate, edge by edge
    wr(8'h04, 32'h8000_0000);
    chk("R3 chan_rst_o", {31'b0, chan_rst_o}, 32'h1);
    for (int k = 1; k <= DLY; k++) begin
      @(negedge clk);
      chk($sformatf("R4 clk_en after edge %0d", k), {31'b0, clk_en_o},
          (k == DLY) ? 32'h0 : 32'h1);
    end
    rd(8'h00, r); chk("R4 ctrl", r, 32'hC000_0000);
    rd(8'h10, r); chk("R8 ch0 cleared", r, RSTV32);
    rd(8'h14, r); chk("R8 ch1 cleared", r, RSTV32);

    // R5 gate release blocked while reset held
    wr(8'h08, 32'h4000_0000);
    rd(8'h00, r); chk("R5 clr alias", r, 32'hC000_0000);
    wr(8'h00, 32'h8000_0000);
    rd(8'h00, r); chk("R5 plain write", r, 32'hC000_0000);
    chk("R5 clk_en_o", {31'b0, clk_en_o}, 32'h0);

    // R6 release reset, gate stays
    wr(8'h08, 32'h8000_0000);
    rd(8'h00, r); chk("R6 ctrl", r, 32'h4000_0000);
    chk("R6 chan_rst_o", {31'b0, chan_rst_o}, 32'h0);
    chk("R6 clk_en_o", {31'b0, clk_en_o}, 32'h0);
    wr(8'h10, 32'h0000_0077);
    rd(8'h10, r); chk("R9 write while gated", r, RSTV32);

    // R7 ungate
    wr(8'h08, 32'h4000_0000);
    chk("R7 clk_en_o", {31'b0, clk_en_o}, 32'h1);
    rd(8'h00, r); chk("R7 ctrl", r, 32'h0);
    wr(8'h10, 32'h0000_0077);
    rd(8'h10, r); chk("R7 write after ungate", r, 32'h0000_0077);

    // R4 abort: drop reset before the count ends
    wr(8'h04, 32'h8000_0000);
    @(negedge clk);
    wr(8'h08, 32'h8000_0000);
    repeat (DLY + 2) @(negedge clk);
    rd(8'h00, r); chk("R4 abort ctrl", r, 32'h0);
    chk("R4 abort clk_en_o", {31'b0, clk_en_o}, 32'h1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule